// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register interface between a host bus and the local processor of a keyboard controller. It is modelled on the classic PC keyboard controller. The host and the local CPU exchange bytes through two one-byte mailboxes. The host-to-CPU slot holds the last byte the host wrote. The CPU-to-host slot holds the last byte the CPU wrote. Each slot has a full flag, and these flags give both sides a simple handshake.

A status byte gathers the two full flags, a command/data marker and five bits that CPU firmware may use freely. On every host write, the single host address line decides whether the byte counts as a command or as data, and the block records that choice in the status byte. The full flags drive one interrupt line toward the host and one toward the local CPU, and each line has its own enable pin.

Top module: `kbc_host_mailbox`

## Requirements
- R1: After reset, the status byte, both data buffers and both interrupt outputs are zero.
- R2: A host write (host_wr_i) loads host_wdata_i into the input buffer. From the next cycle onward, the CPU data read (cpu_addr_i=0) returns that byte and status bit 1 (input full) is 1.
- R3: Every host write copies host_addr_i into status bit 3 (1 = command, 0 = data).
- R4: A CPU data read (cpu_rd_i with cpu_addr_i=0) returns the input buffer in the same cycle and clears status bit 1 on the next edge. If a host write arrives in the same cycle, the flag stays set.
- R5: A host write while status bit 1 is already 1 overwrites the input buffer, and the flag stays 1.
- R6: A CPU data write (cpu_wr_i with cpu_addr_i=0) loads the output buffer and sets status bit 0 (output full) from the next cycle.
- R7: A host read with host_addr_i=0 returns the output buffer and clears status bit 0 on the next edge, unless a CPU data write occurs in the same cycle.
- R8: host_rdata_o shows the status byte while host_addr_i=1, and a host read at that address changes no state.
- R9: host_irq_o equals status bit 0 while host_irq_en_i=1, and stays 0 while host_irq_en_i=0.
- R10: cpu_irq_o equals status bit 1 while cpu_irq_en_i=1, and stays 0 while cpu_irq_en_i=0.
- R11: A CPU status write (cpu_wr_i with cpu_addr_i=1) updates only the firmware bits 2 and 4 to 7. Bits 0, 1 and 3 keep their values. A CPU read at cpu_addr_i=1 returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 1 | Host address: 0 data, 1 command/status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (output buffer or status) |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_addr_i | input | 1 | CPU address: 0 data, 1 status |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (input buffer or status) |
| host_irq_en_i | input | 1 | Enable for the host interrupt |
| cpu_irq_en_i | input | 1 | Enable for the CPU input interrupt |
| host_irq_o | output | 1 | Host interrupt: output buffer full |
| cpu_irq_o | output | 1 | CPU interrupt: input buffer full |

## Verification
Both read ports are combinational, so a read result is due in the same cycle as its strobe. Every flag, buffer and interrupt change is due one edge after the strobe that causes it. The bench drives each stimulus just after a rising edge. For read data, it queues the expected value in that same cycle. For state changes, it queues the expected value after the following edge. The monitor compares all queued values at the falling edge, which keeps same-cycle and next-cycle results apart. The interrupt enables act combinationally, so their checks fall in the cycle the enable changes.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OBF_BIT = 0;
  localparam int unsigned IBF_BIT = 1;
  localparam int unsigned CD_BIT  = 3;
  // bits free for firmware use
  localparam logic [DATA_W-1:0] USER_MASK = 8'hF4;
  typedef logic [DATA_W-1:0] kbc_byte_t;
endpackage

// File: rtl/kbc_mbox_slot.sv
module kbc_mbox_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (load_i) data_o <= data_i;
      // load wins over a same-cycle take
      if (load_i)      full_o <= 1'b1;
      else if (take_i) full_o <= 1'b0;
    end
  end

  // R2
  load_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_o && data_o == $past(data_i));
  // R4
  take_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !load_i |=> !full_o);
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
endmodule

// File: rtl/kbc_status_reg.sv
module kbc_status_reg
  import kbc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         host_wr_i,
  input  logic         host_addr_i,
  input  logic         cpu_st_wr_i,
  input  logic [W-1:0] cpu_wdata_i,
  output logic [W-1:0] user_o,
  output logic         cd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cd_o <= 1'b0;
    else if (host_wr_i) cd_o <= host_addr_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (USER_MASK[i]) begin : g_user
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= 1'b0;
        else if (cpu_st_wr_i) q <= cpu_wdata_i[i];
      end
      assign user_o[i] = q;
    end else begin : g_fixed
      assign user_o[i] = 1'b0;
    end
  end

  // R3
  cd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> cd_o == $past(host_addr_i));
  // R3
  cd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_wr_i |=> $stable(cd_o));
  // R11
  user_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_st_wr_i |=> user_o == ($past(cpu_wdata_i) & USER_MASK));
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
  import kbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic       host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  input  logic       cpu_wr_i,
  input  logic       cpu_rd_i,
  input  logic       cpu_addr_i,
  input  logic [7:0] cpu_wdata_i,
  output logic [7:0] cpu_rdata_o,
  input  logic       host_irq_en_i,
  input  logic       cpu_irq_en_i,
  output logic       host_irq_o,
  output logic       cpu_irq_o
);
  kbc_byte_t in_buf, out_buf, user_bits, status;
  logic      ibf, obf, cd;
  logic      cpu_dat_wr, cpu_st_wr, cpu_dat_rd, host_dat_rd;

  assign cpu_dat_wr  = cpu_wr_i & ~cpu_addr_i;
  assign cpu_st_wr   = cpu_wr_i &  cpu_addr_i;
  assign cpu_dat_rd  = cpu_rd_i & ~cpu_addr_i;
  assign host_dat_rd = host_rd_i & ~host_addr_i;

  kbc_mbox_slot #(.W(DATA_W)) u_in (
    .clk_i, .rst_ni,
    .load_i (host_wr_i),
    .data_i (host_wdata_i),
    .take_i (cpu_dat_rd),
    .data_o (in_buf),
    .full_o (ibf)
  );

  kbc_mbox_slot #(.W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .load_i (cpu_dat_wr),
    .data_i (cpu_wdata_i),
    .take_i (host_dat_rd),
    .data_o (out_buf),
    .full_o (obf)
  );

  kbc_status_reg #(.W(DATA_W)) u_st (
    .clk_i, .rst_ni,
    .host_wr_i   (host_wr_i),
    .host_addr_i (host_addr_i),
    .cpu_st_wr_i (cpu_st_wr),
    .cpu_wdata_i (cpu_wdata_i),
    .user_o      (user_bits),
    .cd_o        (cd)
  );

  always_comb begin
    status          = user_bits;
    status[OBF_BIT] = obf;
    status[IBF_BIT] = ibf;
    status[CD_BIT]  = cd;
  end

  assign host_rdata_o = host_addr_i ? status : out_buf;
  assign cpu_rdata_o  = cpu_addr_i  ? status : in_buf;
  assign host_irq_o   = obf & host_irq_en_i;
  assign cpu_irq_o    = ibf & cpu_irq_en_i;

  // R7
  host_take_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_dat_rd && !cpu_dat_wr |=> !host_irq_o);
  // R8
  status_read_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && host_addr_i && !cpu_wr_i |=> $stable(obf));
  // R11
  flags_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_st_wr && !host_wr_i && !cpu_rd_i && !host_rd_i |=> $stable(ibf) && $stable(obf) && $stable(cd));
endmodule

// File: tb/sim_kbc_host_mailbox.sv
module sim_kbc_host_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_addr = 0;
  logic [7:0] host_wdata = 0, cpu_wdata = 0;
  logic [7:0] host_rdata, cpu_rdata;
  logic host_irq_en = 1, cpu_irq_en = 1;
  logic host_irq, cpu_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  kbc_host_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .host_irq_en_i(host_irq_en), .cpu_irq_en_i(cpu_irq_en),
    .host_irq_o(host_irq), .cpu_irq_o(cpu_irq)
  );

  // sel 0: host_rdata, 1: cpu_rdata, 2: {host_irq, cpu_irq}
  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  function automatic logic [7:0] obs(int sel);
    case (sel)
      0: return host_rdata;
      1: return cpu_rdata;
      default: return {6'b0, host_irq, cpu_irq};
    endcase
  endfunction

  task automatic expect_val(int sel, logic [7:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (q.size() > 0) begin
      it = q.pop_front();
      act = obs(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; cpu_wr = 0; cpu_rd = 0;
  endtask

  task automatic status_is(logic [7:0] exp, string tag);
    host_addr = 1;
    expect_val(0, exp, tag);
  endtask

  task automatic host_write(logic a, logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    status_is(8'h00, "R1 status");
    expect_val(2, 8'h00, "R1 irqs");
    cpu_addr = 0; expect_val(1, 8'h00, "R1 in_buf");
    cyc();
    host_addr = 0; expect_val(0, 8'h00, "R1 out_buf");
    cyc();

    // R2 host data write
    host_write(0, 8'hA5); cyc();
    status_is(8'h02, "R2 ibf set cd=0");
    expect_val(1, 8'hA5, "R2 cpu sees byte");
    expect_val(2, 8'h01, "R10 cpu irq");
    cyc();

    // R4 cpu read clears ibf
    cpu_rd = 1; cpu_addr = 0;
    expect_val(1, 8'hA5, "R4 read data");
    cyc();
    status_is(8'h00, "R4 ibf cleared");
    expect_val(2, 8'h00, "R10 cpu irq dropped");
    cyc();

    // R3 command write
    host_write(1, 8'h3C); cyc();
    status_is(8'h0A, "R3 cd=1");
    expect_val(1, 8'h3C, "R3 data");
    cyc();

    // R5 overwrite while full
    host_write(0, 8'h11); cyc();
    status_is(8'h02, "R5 ibf kept cd=0");
    expect_val(1, 8'h11, "R5 overwrite");
    cyc();

    // R4 same-cycle write and read
    host_write(0, 8'h22); cpu_rd = 1; cpu_addr = 0;
    cyc();
    status_is(8'h02, "R4 set wins");
    expect_val(1, 8'h22, "R4 new byte");
    cpu_rd = 1;
    cyc();
    status_is(8'h00, "R4 cleared");
    cyc();

    // R6 cpu data write
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h5A; cyc();
    status_is(8'h01, "R6 obf set");
    expect_val(2, 8'h02, "R9 host irq");
    cyc();
    host_addr = 0; expect_val(0, 8'h5A, "R6 host sees byte");
    cyc();

    // R9 enable low
    host_irq_en = 0; expect_val(2, 8'h00, "R9 irq masked");
    cyc();
    host_irq_en = 1;

    // R8 status read has no side effect
    host_rd = 1; host_addr = 1;
    expect_val(0, 8'h01, "R8 status read");
    cyc();
    status_is(8'h01, "R8 obf kept");
    cyc();

    // R7 host data read
    host_rd = 1; host_addr = 0;
    expect_val(0, 8'h5A, "R7 read data");
    cyc();
    status_is(8'h00, "R7 obf cleared");
    expect_val(2, 8'h00, "R9 host irq dropped");
    cyc();

    // R7 same-cycle cpu write and host read
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h66;
    host_rd = 1; host_addr = 0;
    expect_val(0, 8'h5A, "R7 old byte");
    cyc();
    status_is(8'h01, "R7 set wins");
    cyc();
    host_addr = 0; expect_val(0, 8'h66, "R7 new byte");
    host_rd = 1;
    cyc();

    // R11 status write
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'hFF; cyc();
    status_is(8'hF4, "R11 user bits only");
    cpu_addr = 1; expect_val(1, 8'hF4, "R11 cpu status read");
    cyc();
    host_write(1, 8'h77); cyc();
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h00; cyc();
    status_is(8'h0A, "R11 flags kept");
    cyc();

    // R10 cpu irq enable
    expect_val(2, 8'h01, "R10 cpu irq on");
    cyc();
    cpu_irq_en = 0; expect_val(2, 8'h00, "R10 cpu irq masked");
    cyc();
    cpu_irq_en = 1;

    cyc();
    @(negedge clk);
    #1 done = 1;
    summary();
    $finish;
  end
endmodule